// File: doc/BRIEF.md
# Snooze Entry/Exit Sequencer

This block steps a synchronous memory controller into and out of a low-power snooze state. A free-running sleep request enters through a synchronizer. Once the request is seen, the block opens an entry window of a fixed number of cycles. During that window deselect and read cycles may still be issued, but writes are refused. The block then parks in the snooze state. There, input sampling is turned off and the data outputs are forced to high impedance. Every other input to the controller is treated as don't-care in that state.

When the synchronized request falls, the block runs a recovery window of the same kind as the entry window. Only after that window closes does it report that full operation, writes included, may resume. The windows are never cut short:
- A request that drops during entry still completes the entry, spends at least one cycle asleep and then performs the full exit.
- A request that returns during exit still lets the exit finish, gives one awake cycle and then starts a fresh entry.

A write attempted inside either window is blocked and latches a sticky error flag. The sleep request takes precedence over every other control input.

Top module: `snooze_seq`

## Requirements
- R1: While reset is held and right after it, sampleEn is 1, forceHiZ is 0, lowPower is 0, wrGrant is 0 and wrErr is 0.
- R2: sleepIn passes through SYNC_STAGES flops before the sequencer sees it. If sleepIn is first sampled high at clock edge 1, lowPower rises just after edge SYNC_STAGES+1.
- R3: The entry window lasts exactly ENTRY_CYC cycles. During it lowPower is 1, sampleEn is 1 and forceHiZ is 0.
- R4: In the snooze state forceHiZ is 1, sampleEn is 0 and lowPower is 1. A wrAttempt there produces neither a grant nor an error.
- R5: The snooze state is left on the first edge at which it sees the synchronized request low. The exit window then lasts exactly EXIT_CYC cycles with lowPower 1, sampleEn 1 and forceHiZ 0. After it, lowPower returns to 0.
- R6: wrGrant equals wrAttempt while lowPower is 0 and is 0 whenever lowPower is 1.
- R7: wrErr goes to 1 on the clock edge at which wrAttempt is 1 during an entry or exit window. It stays 1 until reset.
- R8: If sleepIn is sampled high on edges 1 to L only, the snooze state begins after edge SYNC_STAGES+1+ENTRY_CYC. It ends at edge max(SYNC_STAGES+2+ENTRY_CYC, L+SYNC_STAGES+1), even when the request fell during entry.
- R9: If the request returns during the exit window, the exit completes and lowPower is 0 for at least one cycle before the next entry window begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| sleepIn | input | 1 | Asynchronous snooze request |
| wrAttempt | input | 1 | Controller wants to write in this cycle |
| sampleEn | output | 1 | Controller may sample its inputs |
| forceHiZ | output | 1 | Data outputs must be driven to high impedance |
| lowPower | output | 1 | Sequencer is anywhere in the entry, snooze or exit phase |
| wrGrant | output | 1 | Write is allowed this cycle |
| wrErr | output | 1 | Sticky flag: a write was attempted inside a transition window |

## Verification
Every cycle, the assertions check several invariants:
- sampling is off whenever outputs are forced to high impedance;
- a grant only follows a real attempt outside the low-power phases;
- the error flag, once set, never clears;
- each entry and exit window, measured as the run of cycles in low power without high impedance, has exactly its configured length.

Some behaviour only the bench scenarios can show. These are the synchronizer latency from the raw request, the exact edge at which each phase begins for every request length from one cycle up, the suppression of errors for writes made while asleep, and the forced awake cycle when a request comes back during exit.

// File: rtl/snooze_pkg.sv
package snooze_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_EXIT  = 2'd3
  } snzState_t;

  typedef struct packed {
    logic inWindow;
    logic asleep;
    logic awake;
  } snzStrobe_t;

endpackage

// File: rtl/snooze_sync.sv
module snooze_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/snooze_ctrl.sv
module snooze_ctrl
  import snooze_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSync,
  output snzStrobe_t strb
);
  localparam int MAXC  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYC - 1);

  snzState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    unique case (state)
      ST_AWAKE: if (reqSync) begin
        stateNxt = ST_ENTER;
        cntNxt   = ENTRY_LOAD;
      end
      ST_ENTER: begin
        if (cnt == '0) stateNxt = ST_SLEEP;
        else           cntNxt   = cnt - 1'b1;
      end
      ST_SLEEP: if (!reqSync) begin
        stateNxt = ST_EXIT;
        cntNxt   = EXIT_LOAD;
      end
      ST_EXIT: begin
        if (cnt == '0) stateNxt = ST_AWAKE;
        else           cntNxt   = cnt - 1'b1;
      end
      default: stateNxt = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_AWAKE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    strb.inWindow = (state == ST_ENTER) || (state == ST_EXIT);
    strb.asleep   = (state == ST_SLEEP);
    strb.awake    = (state == ST_AWAKE);
  end
endmodule

// File: rtl/snooze_dp.sv
module snooze_dp
  import snooze_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  snzStrobe_t strb,
  input  logic       wrAttempt,
  output logic       sampleEn,
  output logic       forceHiZ,
  output logic       lowPower,
  output logic       wrGrant,
  output logic       wrErr
);
  logic errQ;

  always_ff @(posedge clk) begin
    if (!rstN)                              errQ <= 1'b0;
    else if (strb.inWindow && wrAttempt)    errQ <= 1'b1;
  end

  assign sampleEn = !strb.asleep;
  assign forceHiZ = strb.asleep;
  assign lowPower = !strb.awake;
  assign wrGrant  = wrAttempt && strb.awake;
  assign wrErr    = errQ;
endmodule

// File: rtl/snooze_seq.sv
module snooze_seq
  import snooze_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepIn,
  input  logic wrAttempt,
  output logic sampleEn,
  output logic forceHiZ,
  output logic lowPower,
  output logic wrGrant,
  output logic wrErr
);
  logic       reqSync;
  snzStrobe_t strb;

  snooze_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(sleepIn), .dout(reqSync)
  );

  snooze_ctrl #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqSync(reqSync), .strb(strb)
  );

  snooze_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAttempt(wrAttempt),
    .sampleEn(sampleEn), .forceHiZ(forceHiZ), .lowPower(lowPower),
    .wrGrant(wrGrant), .wrErr(wrErr)
  );
endmodule

// File: rtl/snooze_seq_chk.sv
module snooze_seq_chk #(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input logic clk,
  input logic rstN,
  input logic wrAttempt,
  input logic sampleEn,
  input logic forceHiZ,
  input logic lowPower,
  input logic wrGrant,
  input logic wrErr
);
  localparam int MAXC  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int RUN_W = $clog2(MAXC + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] winRun;

  always_ff @(posedge clk) begin
    if (!rstN)                       winRun <= '0;
    else if (lowPower && !forceHiZ) winRun <= (winRun == RUN_MAX) ? winRun : winRun + 1'b1;
    else                             winRun <= '0;
  end

  a_r4_hiz_no_sample: assert property (@(posedge clk) disable iff (!rstN)
    forceHiZ |-> !sampleEn);

  a_r6_grant_only_awake: assert property (@(posedge clk) disable iff (!rstN)
    wrGrant |-> (wrAttempt && !lowPower));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |=> wrErr);

  a_r3_entry_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forceHiZ) |-> (winRun == RUN_W'(ENTRY_CYC)));

  a_r5_exit_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lowPower) |-> (winRun == RUN_W'(EXIT_CYC)));

  a_r3_sleep_after_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forceHiZ) |-> $past(lowPower));

  a_r5_exit_keeps_low_power: assert property (@(posedge clk) disable iff (!rstN)
    $fell(forceHiZ) |-> lowPower);
endmodule

bind snooze_seq snooze_seq_chk #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .wrAttempt(wrAttempt), .sampleEn(sampleEn),
  .forceHiZ(forceHiZ), .lowPower(lowPower), .wrGrant(wrGrant), .wrErr(wrErr)
);

// File: tb/tb_snooze_seq.sv
`timescale 1ns/1ps
module tb_snooze_seq;
  localparam int S  = 2;
  localparam int EN = 2;
  localparam int EX = 2;

  logic clk = 1'b0;
  logic rstN, sleepIn, wrAttempt;
  logic sampleEn, forceHiZ, lowPower, wrGrant, wrErr;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  snooze_seq #(.SYNC_STAGES(S), .ENTRY_CYC(EN), .EXIT_CYC(EX)) dut (
    .clk(clk), .rstN(rstN), .sleepIn(sleepIn), .wrAttempt(wrAttempt),
    .sampleEn(sampleEn), .forceHiZ(forceHiZ), .lowPower(lowPower),
    .wrGrant(wrGrant), .wrErr(wrErr)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected phase after t edges for a request sampled high on edges 1..L:
  // 0 awake, 1 entry window, 2 snooze, 3 exit window (R2, R3, R5, R8)
  function automatic int expSt(int t, int L);
    int a, x;
    a = S + 1 + EN;
    x = (a + 1 > L + S + 1) ? a + 1 : L + S + 1;
    if (t < S + 1)  return 0;
    if (t < a)      return 1;
    if (t < x)      return 2;
    if (t < x + EX) return 3;
    return 0;
  endfunction

  task automatic doReset();
    rstN = 1'b0; sleepIn = 1'b0; wrAttempt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "sampleEn in reset", sampleEn, 1'b1);
    chk("R1", "lowPower in reset", lowPower, 1'b0);
    rstN = 1'b1;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Sweep over request length and write pattern
    for (int L = 1; L <= 12; L++) begin
      for (int mode = 0; mode < 4; mode++) begin
        logic errExp;
        int   n;
        errExp = 1'b0;
        n = L + S + EN + EX + 6;
        doReset();
        chk("R1", "forceHiZ after reset", forceHiZ, 1'b0);
        chk("R1", "wrErr after reset", wrErr, 1'b0);
        for (int t = 0; t <= n; t++) begin
          int    st;
          string tag;
          logic  wr;
          st = expSt(t, L);
          if (L <= S) tag = "R8";
          else case (st)
            1: tag = "R3";
            2: tag = "R4";
            3: tag = "R5";
            default: tag = (t < S + 1) ? "R2" : "R5";
          endcase
          chk(tag, "sampleEn", sampleEn, st != 2);
          chk(tag, "forceHiZ", forceHiZ, st == 2);
          chk(tag, "lowPower", lowPower, st != 0);
          chk("R7", "wrErr", wrErr, errExp);
          // drive inputs for edge t+1
          sleepIn = (t + 1 <= L);
          case (mode)
            1: wr = 1'b1;
            2: wr = (st == 2);
            3: wr = (st == 3);
            default: wr = 1'b0;
          endcase
          wrAttempt = wr;
          #1;
          chk("R6", "wrGrant", wrGrant, wr && (st == 0));
          if (wr && (st == 1 || st == 3)) errExp = 1'b1;
          @(posedge clk);
          @(negedge clk);
        end
        // R4: writes only while asleep never flag an error
        if (mode == 2) chk("R4", "no error from asleep writes", wrErr, 1'b0);
      end
    end

    // R9: request returns during exit window
    doReset();
    for (int t = 0; t <= 18; t++) begin
      if (t == 11) chk("R9", "exit at t11 hiZ", forceHiZ, 1'b0);
      if (t == 12) chk("R9", "exit at t12 lowPower", lowPower, 1'b1);
      if (t == 13) chk("R9", "awake gap lowPower", lowPower, 1'b0);
      if (t == 14) chk("R9", "new entry lowPower", lowPower, 1'b1);
      if (t == 14) chk("R9", "new entry hiZ", forceHiZ, 1'b0);
      if (t == 16) chk("R9", "asleep again hiZ", forceHiZ, 1'b1);
      sleepIn = (t + 1 != 9);
      wrAttempt = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule